// File: doc/BRIEF.md
# Interrupt Acknowledge Controller with Bus-Supplied Opcode

This block sits beside the instruction fetch unit of a small processor. When an interrupt request is pending and interrupts are enabled, the controller takes over the next opcode fetch. It marks that fetch on a status output as an acknowledge cycle and tells the fetch unit to use the byte on the data bus in place of a memory read. The requesting device supplies an instruction on the bus, and the controller decodes it.

Two bus-supplied instructions are understood. The first is a one-byte restart of the form 11nnn111, which branches to nnn*8. The second is a three-byte call whose two address bytes come in on further acknowledge cycles, low byte first. Any other byte is reported as unsupported. The program counter is held still on every acknowledge cycle, so the saved return address names the interrupted instruction.

Interrupts are enabled and disabled by two instruction strobes. Accepting an interrupt disables them, and only a later enable instruction turns them back on. There is no non-maskable request. There is no vector table.

Top module: `irq_jam_ctrl`

## Requirements
- R1: `bus_status` is 2'b00 in a cycle without `fetch_stb`, 2'b01 for a normal opcode fetch and 2'b10 for an acknowledge cycle.
- R2: From the idle state, a `fetch_stb` cycle is an acknowledge cycle exactly when `irq_req` and `int_en` are both high. In that cycle `fetch_override` is high and `pc_adv` is low. Otherwise the fetch is normal, with `pc_adv` high and `fetch_override` low.
- R3: `int_en` is 0 after reset. `ei_stb` sets it from the next cycle and `di_stb` clears it from the next cycle. `di_stb` wins when both strobes arrive together. A strobe does not affect acceptance in its own cycle.
- R4: Accepting a request clears `int_en` from the next cycle, even if `ei_stb` arrives in the same cycle. It stays cleared through later requests until a new `ei_stb`.
- R5: A restart byte 11nnn111 seen on an acknowledge cycle raises `done_stb` and `push_stb` for one cycle, starting the cycle after. At the same time `op_code` is set to the byte and `tgt_addr` to nnn*8.
- R6: The call byte 8'hCD makes the next two `fetch_stb` cycles acknowledge cycles, whatever `irq_req` and `int_en` are. These cycles capture the low and then the high address byte. The cycle after the high byte, `done_stb` and `push_stb` pulse with `op_code` = 8'hCD and `tgt_addr` = {high, low}. No `done_stb` is raised earlier in the sequence.
- R7: Any other bus byte on an acknowledge cycle raises `done_stb` and `bad_op` for one cycle, with `push_stb` low. `op_code` takes the byte and `tgt_addr` is unchanged.
- R8: `pc_adv` is low on every acknowledge cycle, including the two operand cycles of a call.
- R9: `op_code` and `tgt_addr` are 0 after reset and change only in a cycle where `done_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Level interrupt request |
| fetch_stb | input | 1 | Opcode fetch cycle at an instruction boundary |
| ei_stb | input | 1 | Enable-interrupts instruction executed |
| di_stb | input | 1 | Disable-interrupts instruction executed |
| jam_data | input | 8 | Data bus byte driven by the interrupting device |
| bus_status | output | 2 | Cycle status code (none / fetch / acknowledge) |
| fetch_override | output | 1 | Use the bus byte instead of a memory read |
| pc_adv | output | 1 | Program counter may advance for this fetch |
| int_en | output | 1 | Interrupt enable flag |
| done_stb | output | 1 | Bus-supplied instruction fully decoded |
| push_stb | output | 1 | Push current program counter and branch to `tgt_addr` |
| bad_op | output | 1 | Bus-supplied byte is not supported |
| op_code | output | 8 | Last decoded bus-supplied opcode |
| tgt_addr | output | 16 | Branch target of the last restart or call |

## Verification
A sequencer stuck in a call-operand state would show at once: the next ordinary fetch would appear on `bus_status` as an acknowledge cycle with `pc_adv` low, even with no request pending. A flag that fails to clear would show on the very next fetch with the request still high, because that fetch would be acknowledged a second time. Decode errors appear one cycle after the acknowledge, on `tgt_addr`, `push_stb` and `bad_op`. The bench sweeps all 256 bus bytes to catch them.

// File: rtl/irq_jam_pkg.sv
package irq_jam_pkg;
    localparam int JAM_DW = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LO   = 2'd1,
        SEQ_HI   = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'b00,
        BUS_FETCH = 2'b01,
        BUS_ACK   = 2'b10
    } bus_e;

    typedef enum logic [1:0] {
        KIND_RST  = 2'd0,
        KIND_CALL = 2'd1,
        KIND_BAD  = 2'd2
    } kind_e;
endpackage

// File: rtl/irq_en_flag.sv
module irq_en_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (set_i) en_d = 1'b1;
        if (clr_i) en_d = 1'b0;
        if (ack_i) en_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/jam_decode.sv
module jam_decode
    import irq_jam_pkg::*;
#(
    parameter int             DW        = JAM_DW,
    parameter int             AW        = 2 * DW,
    parameter logic [DW-1:0]  CALL_OPC  = 8'hCD,
    parameter int             RST_SHIFT = 3
) (
    input  logic [DW-1:0] byte_i,
    output kind_e         kind_o,
    output logic [AW-1:0] rst_tgt_o
);
    localparam int FLD_W = 3;

    logic is_rst;
    assign is_rst = (byte_i[DW-1 -: 2] == 2'b11) && (byte_i[FLD_W-1:0] == {FLD_W{1'b1}});

    always_comb begin
        if (is_rst)                 kind_o = KIND_RST;
        else if (byte_i == CALL_OPC) kind_o = KIND_CALL;
        else                        kind_o = KIND_BAD;
        rst_tgt_o = {{(AW-FLD_W){1'b0}}, byte_i[2*FLD_W-1:FLD_W]} << RST_SHIFT;
    end
endmodule

// File: rtl/irq_jam_ctrl.sv
module irq_jam_ctrl
    import irq_jam_pkg::*;
#(
    parameter int            DW        = JAM_DW,
    parameter logic [DW-1:0] CALL_OPC  = 8'hCD,
    parameter int            RST_SHIFT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic          fetch_stb,
    input  logic          ei_stb,
    input  logic          di_stb,
    input  logic [DW-1:0] jam_data,
    output logic [1:0]    bus_status,
    output logic          fetch_override,
    output logic          pc_adv,
    output logic          int_en,
    output logic          done_stb,
    output logic          push_stb,
    output logic          bad_op,
    output logic [DW-1:0] op_code,
    output logic [2*DW-1:0] tgt_addr
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        seq_e          seq;
        logic [DW-1:0] lo;
        logic          done;
        logic          push;
        logic          bad;
        logic [DW-1:0] opc;
        logic [AW-1:0] tgt;
    } ctl_s;

    ctl_s          st_d, st_q;
    kind_e         kind;
    logic [AW-1:0] rst_tgt;
    logic          busy, accept, ack;

    jam_decode #(
        .DW(DW), .AW(AW), .CALL_OPC(CALL_OPC), .RST_SHIFT(RST_SHIFT)
    ) u_dec (
        .byte_i   (jam_data),
        .kind_o   (kind),
        .rst_tgt_o(rst_tgt)
    );

    irq_en_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(ei_stb),
        .clr_i(di_stb),
        .ack_i(accept),
        .en_o (int_en)
    );

    assign busy   = (st_q.seq != SEQ_IDLE);
    assign accept = fetch_stb && !busy && irq_req && int_en;
    assign ack    = fetch_stb && (busy || accept);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.push = 1'b0;
        st_d.bad  = 1'b0;
        case (st_q.seq)
            SEQ_IDLE: begin
                if (accept) begin
                    case (kind)
                        KIND_RST: begin
                            st_d.done = 1'b1;
                            st_d.push = 1'b1;
                            st_d.opc  = jam_data;
                            st_d.tgt  = rst_tgt;
                        end
                        KIND_CALL: st_d.seq = SEQ_LO;
                        default: begin
                            st_d.done = 1'b1;
                            st_d.bad  = 1'b1;
                            st_d.opc  = jam_data;
                        end
                    endcase
                end
            end
            SEQ_LO: begin
                if (fetch_stb) begin
                    st_d.lo  = jam_data;
                    st_d.seq = SEQ_HI;
                end
            end
            SEQ_HI: begin
                if (fetch_stb) begin
                    st_d.done = 1'b1;
                    st_d.push = 1'b1;
                    st_d.opc  = CALL_OPC;
                    st_d.tgt  = {jam_data, st_q.lo};
                    st_d.seq  = SEQ_IDLE;
                end
            end
            default: st_d.seq = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seq: SEQ_IDLE, lo: '0, done: 1'b0, push: 1'b0,
                              bad: 1'b0, opc: '0, tgt: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        if (!fetch_stb) bus_status = BUS_NONE;
        else if (ack)   bus_status = BUS_ACK;
        else            bus_status = BUS_FETCH;
    end

    assign fetch_override = ack;
    assign pc_adv         = fetch_stb && !ack;
    assign done_stb       = st_q.done;
    assign push_stb       = st_q.push;
    assign bad_op         = st_q.bad;
    assign op_code        = st_q.opc;
    assign tgt_addr       = st_q.tgt;
endmodule

// File: rtl/irq_jam_chk.sv
module irq_jam_chk #(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] CALL_OPC = 8'hCD
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_stb,
    input logic            ei_stb,
    input logic            di_stb,
    input logic            busy,
    input logic [1:0]      bus_status,
    input logic            fetch_override,
    input logic            pc_adv,
    input logic            int_en,
    input logic            done_stb,
    input logic            push_stb,
    input logic            bad_op,
    input logic [DW-1:0]   op_code,
    input logic [2*DW-1:0] tgt_addr
);
    assert_no_fetch_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stb |-> bus_status == 2'b00);

    assert_first_ack_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_override && !busy) |-> int_en);

    assert_ack_holds_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_override |-> (!pc_adv && bus_status == 2'b10));

    assert_di_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        di_stb |=> !int_en);

    assert_ei_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_stb && !di_stb && !(fetch_override && !busy)) |=> int_en);

    assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_override && !busy) |=> !int_en);

    assert_push_is_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_stb |-> (done_stb && !bad_op));

    assert_rst_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_stb && op_code != CALL_OPC) |-> tgt_addr[2:0] == 3'b000);

    assert_bad_keeps_tgt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (done_stb && !push_stb && $stable(tgt_addr)));

    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_stb |-> ($stable(op_code) && $stable(tgt_addr)));
endmodule

bind irq_jam_ctrl irq_jam_chk #(.DW(DW), .CALL_OPC(CALL_OPC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_stb     (fetch_stb),
    .ei_stb        (ei_stb),
    .di_stb        (di_stb),
    .busy          (busy),
    .bus_status    (bus_status),
    .fetch_override(fetch_override),
    .pc_adv        (pc_adv),
    .int_en        (int_en),
    .done_stb      (done_stb),
    .push_stb      (push_stb),
    .bad_op        (bad_op),
    .op_code       (op_code),
    .tgt_addr      (tgt_addr)
);

// File: tb/test_irq_jam_ctrl.sv
`timescale 1ns/1ps
module test_irq_jam_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, fetch_stb = 1'b0, ei_stb = 1'b0, di_stb = 1'b0;
    logic [7:0]  jam_data = 8'h00;
    logic [1:0]  bus_status;
    logic        fetch_override, pc_adv, int_en, done_stb, push_stb, bad_op;
    logic [7:0]  op_code;
    logic [15:0] tgt_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] c_status;
    logic       c_ovr, c_pcadv;
    logic [15:0] exp_tgt = 16'h0000;

    always #2.5 clk = ~clk;

    irq_jam_ctrl i_irq_jam_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fetch_stb(fetch_stb),
        .ei_stb(ei_stb), .di_stb(di_stb), .jam_data(jam_data),
        .bus_status(bus_status), .fetch_override(fetch_override), .pc_adv(pc_adv),
        .int_en(int_en), .done_stb(done_stb), .push_stb(push_stb), .bad_op(bad_op),
        .op_code(op_code), .tgt_addr(tgt_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic irq, input logic ei,
                        input logic di, input logic [7:0] d);
        @(negedge clk);
        fetch_stb = f; irq_req = irq; ei_stb = ei; di_stb = di; jam_data = d;
        #1;
        c_status = bus_status; c_ovr = fetch_override; c_pcadv = pc_adv;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_normal(input string req);
        chk({req, " status"}, int'(c_status), 1);
        chk({req, " pc_adv"}, int'(c_pcadv), 1);
        chk({req, " override"}, int'(c_ovr), 0);
    endtask

    task automatic chk_ack(input string req);
        chk({req, " status"}, int'(c_status), 2);
        chk({req, " pc_adv"}, int'(c_pcadv), 0);
        chk({req, " override"}, int'(c_ovr), 1);
    endtask

    task automatic do_call(input logic [7:0] lo, input logic [7:0] hi);
        step(1, 1, 0, 0, 8'hCD);
        chk_ack("R2 call accept");
        chk("R6 no done on opcode", int'(done_stb), 0);
        chk("R4 flag cleared", int'(int_en), 0);
        step(0, 0, 0, 0, 8'h00);
        step(1, 0, 0, 0, lo);
        chk_ack("R8 call low byte");
        chk("R6 no done on low", int'(done_stb), 0);
        step(1, 0, 0, 0, hi);
        chk_ack("R8 call high byte");
        chk("R6 done", int'(done_stb), 1);
        chk("R6 push", int'(push_stb), 1);
        chk("R6 bad", int'(bad_op), 0);
        chk("R6 opcode", int'(op_code), 8'hCD);
        chk("R6 target", int'(tgt_addr), int'({hi, lo}));
        exp_tgt = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset status", int'(bus_status), 0);
        chk("R3 reset int_en", int'(int_en), 0);
        chk("R9 reset opcode", int'(op_code), 0);
        chk("R9 reset target", int'(tgt_addr), 0);

        step(1, 1, 0, 0, 8'hFF);
        chk_normal("R3 disabled after reset");
        chk("R3 no done", int'(done_stb), 0);

        step(1, 1, 1, 0, 8'hFF);
        chk_normal("R3 ei not same cycle");
        chk("R3 ei sets", int'(int_en), 1);

        step(1, 0, 0, 0, 8'hFF);
        chk_normal("R2 no request");
        chk("R2 flag kept", int'(int_en), 1);
        step(0, 1, 0, 0, 8'hFF);
        chk("R1 no fetch status", int'(c_status), 0);
        chk("R2 no fetch no done", int'(done_stb), 0);

        step(0, 0, 1, 1, 8'h00);
        chk("R3 di wins", int'(int_en), 0);
        step(0, 0, 1, 0, 8'h00);
        step(1, 1, 0, 1, 8'hFF);
        chk_ack("R3 di not same cycle");
        chk("R3 di clears", int'(int_en), 0);
        chk("R5 done", int'(done_stb), 1);
        exp_tgt = 16'h0038;

        step(0, 0, 1, 0, 8'h00);
        step(1, 1, 1, 0, 8'hC7);
        chk_ack("R4 accept with ei");
        chk("R4 ack beats ei", int'(int_en), 0);
        exp_tgt = 16'h0000;

        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            bb = b[7:0];
            step(0, 0, 1, 0, 8'h00);
            chk("R3 ei sets", int'(int_en), 1);
            if (bb == 8'hCD) begin
                do_call(8'h5A, 8'hA5);
            end else begin
                step(1, 1, 0, 0, bb);
                chk_ack("R2 accept");
                chk("R4 flag cleared", int'(int_en), 0);
                chk("R5 done", int'(done_stb), 1);
                chk("R9 opcode", int'(op_code), b);
                if (bb[7:6] == 2'b11 && bb[2:0] == 3'b111) begin
                    exp_tgt = 16'(int'(bb[5:3]) * 8);
                    chk("R5 push", int'(push_stb), 1);
                    chk("R5 bad", int'(bad_op), 0);
                    chk("R5 target", int'(tgt_addr), int'(exp_tgt));
                end else begin
                    chk("R7 push", int'(push_stb), 0);
                    chk("R7 bad", int'(bad_op), 1);
                    chk("R7 target kept", int'(tgt_addr), int'(exp_tgt));
                end
            end
            step(1, 1, 0, 0, 8'hFF);
            chk_normal("R4 stays disabled");
            chk("R9 no done", int'(done_stb), 0);
            step(0, 1, 0, 0, 8'h00);
            chk("R9 opcode held", int'(op_code), b);
            chk("R9 target held", int'(tgt_addr), int'(exp_tgt));
        end

        for (int k = 0; k < 16; k++) begin
            step(0, 0, 1, 0, 8'h00);
            do_call(8'(k * 17), 8'(~(k * 13)));
            step(1, 1, 0, 0, 8'hFF);
            chk_normal("R6 idle after call");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule